// File: doc/BRIEF.md
# Strobed FIFO with Read Rewind and Half-Level Flag

A single-clock, 9-bit first-in/first-out store driven by active-low write and read strobes. A write or read starts when the clock samples a high-to-low transition on its strobe. Holding a strobe low does not start further operations. A write is refused while the store holds its full depth of words, and a read is refused while it holds none. A refused strobe is dropped and not queued. Three active-low flags report the level: empty, full, and a half-level flag. The half-level flag asserts on a write and is released only on the rising edge of a read strobe.

An active-low rewind input moves the read pointer back to location zero and leaves the write pointer where it is. The words written since reset can then be read out again. The level becomes the number of words written since reset, capped at the depth, and the flags follow that level. Read data is registered and comes with an output-enable bit. The bit stands in for the undriven state of the data pins between reads.

Top module: `rt_fifo`

## Requirements
- R1: While `rst_n` is low, and directly after it, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_oe` is 0.
- R2: The first clock edge that samples `wr_n` low after sampling it high stores `din` at the next location. Holding `wr_n` low for more cycles stores nothing more.
- R3: The first clock edge that samples `rd_n` low after sampling it high, with words stored, loads the oldest word onto `dout` and sets `dout_oe` to 1. Both hold while `rd_n` stays low. Words come out in the order they were written.
- R4: One clock after `rd_n` is sampled high, `dout_oe` is 0.
- R5: `empty_n` is 0 exactly when no words are stored. A read strobe at that time leaves `dout_oe` at 0 and does not move the read pointer, so the next word written is the next word read.
- R6: `full_n` is 0 exactly when DEPTH words are stored. A write strobe at that time stores nothing, and the refused word never appears on `dout`.
- R7: `half_n` goes to 0 in the clock of the write that brings the level above DEPTH/2.
- R8: Once low, `half_n` stays 0 while `rd_n` is held low, even if the level is already at or below DEPTH/2. It returns to 1 on the clock that samples the rising edge of `rd_n`, if the level is then at most DEPTH/2.
- R9: A falling edge on `rt_n` resets the read pointer to location zero and leaves the write pointer unchanged. Later reads replay the words written since reset, oldest first.
- R10: After a rewind, the level equals the number of words written since reset, capped at DEPTH. `empty_n`, `full_n` and `half_n` (set when the level is above DEPTH/2) follow this level.
- R11: A write strobe and a read strobe seen in the same clock both take effect, provided neither is blocked. The level is unchanged and the data order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low read rewind |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Registered read data |
| dout_oe | output | 1 | High while `dout` is being driven by a read |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when above half level; cleared on a read-strobe rise |

## Verification
Single writes followed by single reads check ordering and the strobe edge rule. A write strobe held low for several cycles separates edge detection from level detection. Filling to the full depth and then writing once more shows whether a refused word leaks into the data stream. A read on an empty store shows whether the read pointer moves.

A read that takes the level down to half while its strobe is held low separates the set point of the half-level flag from its release point. A cycle with both strobes falling together checks that the write and the read are counted together. Rewinds are tried after a partial drain and after a full drain of more than half the depth. This checks the replayed data and the recomputed flags.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;

  // Strobe events decoded from the sampled control inputs
  typedef struct packed {
    logic wr;       // write strobe falling edge
    logic rd;       // read strobe falling edge
    logic rd_rise;  // read strobe rising edge
    logic rt;       // rewind falling edge
  } fifo_evt_t;

endpackage

// File: rtl/rt_fifo_strobe_reg.sv
module rt_fifo_strobe_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] q_n
);

  // One sample per strobe; idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_n <= '1;
    else        q_n <= lvl_n;
  end

endmodule

// File: rtl/rt_fifo_store.sv
module rt_fifo_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rt_fifo_ctrl.sv
module rt_fifo_ctrl
  import rt_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_evt_t     req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);

  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
  localparam bit            POW2     = (DEPTH & (DEPTH - 1)) == 0;

  logic [AW-1:0] wr_ptr, wr_ptr_nxt, wr_inc;
  logic [AW-1:0] rd_ptr, rd_ptr_nxt, rd_inc;
  logic [CW-1:0] level, level_nxt;
  logic [CW-1:0] written, written_nxt;
  logic          half_q, half_nxt;

  // Pointer increment: free wrap for power-of-two depths, compare otherwise
  generate
    if (POW2) begin : g_wrap_p2
      assign wr_inc = wr_ptr + AW'(1);
      assign rd_inc = rd_ptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  // Strobes are ignored during a rewind and while blocked
  assign wr_en = req.wr && !req.rt && (level != LVL_FULL);
  assign rd_en = req.rd && !req.rt && (level != '0);

  always_comb begin
    wr_ptr_nxt  = wr_en ? wr_inc : wr_ptr;
    written_nxt = (wr_en && written != LVL_FULL) ? written + CW'(1) : written;
    if (req.rt) begin
      rd_ptr_nxt = '0;
      level_nxt  = written;
      half_nxt   = written > LVL_HALF;
    end else begin
      rd_ptr_nxt = rd_en ? rd_inc : rd_ptr;
      level_nxt  = level + CW'(wr_en) - CW'(rd_en);
      if (wr_en && level_nxt > LVL_HALF)
        half_nxt = 1'b1;
      else if (req.rd_rise && level_nxt <= LVL_HALF)
        half_nxt = 1'b0;
      else
        half_nxt = half_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      written <= '0;
      half_q  <= 1'b0;
    end else begin
      wr_ptr  <= wr_ptr_nxt;
      rd_ptr  <= rd_ptr_nxt;
      level   <= level_nxt;
      written <= written_nxt;
      half_q  <= half_nxt;
    end
  end

  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;
  assign empty_n = level != '0;
  assign full_n  = level != LVL_FULL;
  assign half_n  = !half_q;

  // R6: the level never exceeds the depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_FULL);

  // R5: a read strobe on an empty store leaves the read pointer alone
  assert_empty_holds_rdptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !req.rt) |=> rd_ptr == $past(rd_ptr));

  // R6: a write strobe on a full store leaves the write pointer alone
  assert_full_holds_wrptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_FULL) |=> wr_ptr == $past(wr_ptr));

  // R9: rewind zeroes the read pointer and keeps the write pointer
  assert_rewind_ptrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req.rt |=> (rd_ptr == '0 && wr_ptr == $past(wr_ptr)));

  // R8: the half flag is released only by a read-strobe rise or a rewind
  assert_half_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_q) |-> ($past(req.rd_rise) || $past(req.rt)));

endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
  import rt_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);

  logic [2:0]       strobe_q_n;
  fifo_evt_t        evt;
  logic             wr_en, rd_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [WIDTH-1:0] rdata;
  logic [WIDTH-1:0] dout_nxt;
  logic             oe_nxt;

  rt_fifo_strobe_reg #(.N(3)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n ({rt_n, rd_n, wr_n}),
    .q_n   (strobe_q_n)
  );

  always_comb begin
    evt.wr      = strobe_q_n[0] && !wr_n;
    evt.rd      = strobe_q_n[1] && !rd_n;
    evt.rd_rise = !strobe_q_n[1] && rd_n;
    evt.rt      = strobe_q_n[2] && !rt_n;
  end

  rt_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (evt),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  rt_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (din),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  // Output stage: load on an accepted read, drive until the strobe rises
  always_comb begin
    dout_nxt = rd_en ? rdata : dout;
    oe_nxt   = rd_en || (dout_oe && !rd_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= dout_nxt;
      dout_oe <= oe_nxt;
    end
  end

  // R4: output released one clock after the read strobe is seen high
  assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> !dout_oe);

  // R3: an accepted read drives the output on the next clock
  assert_oe_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dout_oe);

endmodule

// File: tb/rt_fifo_bench.sv
module rt_fifo_bench;

  localparam int W     = 9;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_n, rd_n, rt_n;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic         dout_oe, empty_n, full_n, half_n;

  always #5 clk = ~clk;

  rt_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_rt_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  int vectors = 0;
  int miscompares = 0;

  logic [W-1:0] model[$];   // words the store should hold
  logic [W-1:0] hist[$];    // words written since reset
  logic [W-1:0] expq[$];    // words the monitor should see next
  bit           m_half;
  logic         oe_prev = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check({tag, " empty_n R5"}, 32'(empty_n), 32'(model.size() != 0));
    check({tag, " full_n R6"},  32'(full_n),  32'(model.size() != DEPTH));
    check({tag, " half_n R7/R8"}, 32'(half_n), 32'(!m_half));
  endtask

  // Monitor: compare each newly driven output word with the scoreboard
  always @(negedge clk) begin
    if (dout_oe && !oe_prev) begin
      if (expq.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R5 unexpected read data actual=%0h expected=none", dout);
      end else begin
        check("read order R3", 32'(dout), 32'(expq.pop_front()));
      end
    end
    oe_prev = dout_oe;
  end

  task automatic do_reset();
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    check("reset empty_n R1", 32'(empty_n), 0);
    check("reset full_n R1",  32'(full_n),  1);
    check("reset half_n R1",  32'(half_n),  1);
    check("reset oe R1",      32'(dout_oe), 0);
    rst_n = 1'b1;
    model.delete(); hist.delete(); expq.delete(); m_half = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [W-1:0] d, input int hold);
    @(negedge clk);
    wr_n = 1'b0; din = d;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1;
    if (model.size() < DEPTH) begin
      model.push_back(d);
      if (hist.size() < DEPTH) hist.push_back(d);
      if (model.size() > HALF) m_half = 1;
    end
  endtask

  // Read with the strobe held low for 'hold' cycles
  task automatic do_read(input int hold);
    bit had;
    @(negedge clk);
    had = model.size() != 0;
    if (had) expq.push_back(model.pop_front());
    rd_n = 1'b0;
    repeat (hold) begin
      @(negedge clk);
      check("oe while strobe low R3/R5", 32'(dout_oe), 32'(had));
      if (had) check("half_n held while strobe low R8", 32'(half_n), 32'(!m_half));
    end
    rd_n = 1'b1;
    @(negedge clk);
    check("oe after strobe rise R4", 32'(dout_oe), 0);
    if (model.size() <= HALF) m_half = 0;
  endtask

  task automatic do_rewind();
    @(negedge clk);
    rt_n = 1'b0;
    @(negedge clk);
    rt_n = 1'b1;
    model = hist;
    m_half = model.size() > HALF;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    vectors++; miscompares++;
    $display("FAIL watchdog (R1..R11 incomplete) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();

    // R5: read on empty is ignored, pointer not moved
    do_read(1);
    check_flags("empty read");
    do_write(9'h101, 1);
    check_flags("after first write");
    // R2: strobe held low three cycles stores once
    do_write(9'h0A5, 3);
    do_write(9'h033, 1);
    check_flags("three words R2");
    do_read(1); do_read(2); do_read(1);
    check_flags("drained");
    do_read(1);
    check_flags("empty again R5");

    // R6/R7: fill to depth, then one refused write
    for (int i = 0; i < DEPTH; i++) begin
      do_write(9'((i * 37 + 5) & 9'h1FF), 1);
      @(negedge clk);
      check_flags($sformatf("fill %0d R7", i));
    end
    do_write(9'h1FF, 1);
    @(negedge clk);
    check_flags("refused write R6");

    // R8: drain to HALF+1, then a held read crosses half
    while (model.size() > HALF + 1) do_read(1);
    check_flags("at half+1");
    do_read(3);
    check_flags("half released R8");

    // R11: simultaneous read and write
    @(negedge clk);
    wr_n = 1'b0; rd_n = 1'b0; din = 9'h055;
    expq.push_back(model.pop_front());
    model.push_back(9'h055); hist.push_back(9'h055);
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    check_flags("simultaneous R11");
    while (model.size() > 0) do_read(1);
    check_flags("drained after R11");

    // R9/R10: rewind after a partial drain
    do_reset();
    for (int i = 0; i < 5; i++) do_write(9'(9'h0F0 + i), 1);
    do_read(1); do_read(1);
    do_rewind();
    check_flags("rewind partial R10");
    while (model.size() > 0) do_read(1);

    // R9/R10: rewind after a full drain of more than half
    do_reset();
    for (int i = 0; i < HALF + 2; i++) do_write(9'(9'h140 + i), 1);
    while (model.size() > 0) do_read(1);
    check_flags("drained before rewind");
    do_rewind();
    check_flags("rewind full R10");
    while (model.size() > 0) do_read(1);
    check_flags("replay done R9");

    repeat (3) @(negedge clk);
    check("scoreboard empty R3", 32'(expq.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule